// File: doc/BRIEF.md
# Debug Register-Access Program Generator

This block serves a debug module that reaches a halted hart's registers by placing a short machine-code routine into a small instruction buffer and letting the hart run it. On a start strobe it decodes a register-access command: register number, transfer enable, direction, access size and a run-on flag. It then streams the matching 32-bit instruction words into the buffer, one word per accepted handshake. When the last word has gone out it pulses `done` with the word count, or it reports a "not supported" error code.

Data moves between the hart and the debugger through a data word at a fixed memory offset, `DATA_OFF`, which defaults to 0x380. Any target that is floating-point state gets a prologue and an epilogue. The prologue parks s0 and mstatus in the two debug scratch CSRs and forces the mstatus FS field on. The epilogue puts mstatus and s0 back. This keeps FP registers reachable even when the hart has FS off.

The write port follows valid/ready rules. `buf_valid` stays high for the whole routine. Address and data hold steady while `buf_ready` is low. A word is consumed only on a cycle where both are high.

Top module: `dbg_regacc_seq`

## Requirements
- R1: After reset `buf_valid`, `done` and `err_set` are low.
- R2: Register numbers 0x1000..0x101F select GPR x(regno-0x1000). A read emits `sw xN, DATA_OFF(x0)` and a write emits `lw xN, DATA_OFF(x0)`, followed by the final word (2 words in total).
- R3: A non-FP CSR (regno below 0x1000, other than 0x001..0x003) emits the following words in order: `csrrw x0, s0, 0x7B2`, the access, `csrrs s0, x0, 0x7B2`, and the final word. A CSR read uses CSRRS encoded as (csr<<20)|(rs1<<15)|(2<<12)|(rd<<7)|0x73 with rs1=0. A write uses the same layout with funct3=1. The access for a read is `csrr s0,csr; sw s0,DATA_OFF(x0)` and for a write is `lw s0,DATA_OFF(x0); csrw csr,s0`.
- R4: Register numbers 0x1020..0x103F are FP registers f(regno-0x1020), accessed with fsw (read) or flw (write). The access is wrapped as follows. The prologue is `csrw 0x7B2,s0; csrr s0,0x300; csrw 0x7B3,s0; lui s0,0x6; csrrs x0,s0,0x300`. The epilogue is `csrr s0,0x7B3; csrw 0x300,s0; csrr s0,0x7B2`. This gives 10 words.
- R5: The FP CSRs 0x001, 0x002 and 0x003 get the R4 prologue and epilogue around the R3 access, without the R3 s0 save and restore. This gives 11 words, which fits the 12-word buffer.
- R6: The final word is EBREAK (0x00100073), or NOP (0x00000013) when `cmd_postexec` is set. With `cmd_transfer` low, only the final word is emitted, whatever the register number.
- R7: With transfer set, a register number of 0x1040 or above, or a size other than 2 (32-bit), produces no buffer writes. Instead, one cycle after start, `done`=1, `err_set`=1, `err_code`=2 and `done_count`=0.
- R8: A start while `err_in` is nonzero is ignored: no buffer writes and no `done`.
- R9: Buffer addresses run 0,1,2,... with one address per handshake. While `buf_valid` is high and `buf_ready` is low, address and data stay stable.
- R10: `done` pulses for one cycle, in the cycle after the last handshake, with `done_count` equal to the number of words written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_regno | input | 16 | Register number |
| cmd_transfer | input | 1 | Perform the register transfer |
| cmd_write | input | 1 | 1 = write the register from the data word |
| cmd_size | input | 3 | Access size code, only 2 (32-bit) supported |
| cmd_postexec | input | 1 | End with NOP instead of EBREAK |
| err_in | input | 3 | Current command-error state |
| buf_valid | output | 1 | Buffer write word valid |
| buf_ready | input | 1 | Buffer accepts the word |
| buf_addr | output | 4 | Buffer word index |
| buf_data | output | 32 | Instruction word |
| done | output | 1 | Command finished pulse |
| done_count | output | 4 | Words written by the command |
| err_set | output | 1 | Error pulse, together with done |
| err_code | output | 3 | Error code, 2 = not supported |

## Verification
The assertions assume that the command inputs stay unchanged from the start strobe until `done`, because the routine is rebuilt from them every cycle. They also assume that `buf_ready` can be any value at any time. The bench drives each command field only at a falling edge before the start strobe and leaves it untouched until it has observed `done` or its wait window has closed. In one scenario the bench toggles `buf_ready` irregularly so that the back-pressure rules are exercised.

// File: rtl/dbg_regacc_pkg.sv
package dbg_regacc_pkg;
  typedef enum logic [1:0] {K_CSR, K_GPR, K_FPR, K_BAD} rkind_e;

  localparam logic [4:0]  REG_S0    = 5'd8;
  localparam logic [11:0] CSR_MSTAT = 12'h300;
  localparam logic [11:0] CSR_SCR0  = 12'h7B2;
  localparam logic [11:0] CSR_SCR1  = CSR_SCR0 + 12'h1;
  localparam logic [19:0] FS_UPPER  = 20'h00006;
  localparam logic [31:0] W_EBREAK  = 32'h0010_0073;
  localparam logic [31:0] W_NOP     = 32'h0000_0013;
  localparam logic [2:0]  ERR_NOSUP = 3'd2;
  localparam logic [2:0]  SIZE_W32  = 3'd2;

  function automatic logic [31:0] enc_csr(input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [4:0] rs1, input logic [11:0] csr);
    return (32'(csr) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'h73;
  endfunction

  function automatic logic [31:0] enc_load(input logic [6:0] op, input logic [4:0] rd,
                                           input logic [11:0] off);
    return (32'(off) << 20) | (32'h2 << 12) | (32'(rd) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] enc_store(input logic [6:0] op, input logic [4:0] rs2,
                                            input logic [11:0] off);
    return (32'(off[11:5]) << 25) | (32'(rs2) << 20) | (32'h2 << 12) |
           (32'(off[4:0]) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] enc_lui(input logic [4:0] rd, input logic [19:0] imm);
    return (32'(imm) << 12) | (32'(rd) << 7) | 32'h37;
  endfunction
endpackage

// File: rtl/dbg_regacc_classify.sv
module dbg_regacc_classify
  import dbg_regacc_pkg::*;
(
  input  logic [15:0] regno,
  output rkind_e      kind,
  output logic        is_fp,
  output logic [4:0]  idx
);
  logic fp_csr;
  always_comb begin
    fp_csr = (regno == 16'h0001) || (regno == 16'h0002) || (regno == 16'h0003);
    idx    = regno[4:0];
    if (regno < 16'h1000)      kind = K_CSR;
    else if (regno < 16'h1020) kind = K_GPR;
    else if (regno < 16'h1040) kind = K_FPR;
    else                       kind = K_BAD;
    is_fp = fp_csr || (kind == K_FPR);
  end
endmodule

// File: rtl/dbg_regacc_prog.sv
module dbg_regacc_prog
  import dbg_regacc_pkg::*;
#(
  parameter int          DEPTH    = 12,
  parameter logic [11:0] DATA_OFF = 12'h380,
  parameter bit          CSR_EN   = 1'b1,
  localparam int         AW       = $clog2(DEPTH),
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  rkind_e                 kind,
  input  logic                   is_fp,
  input  logic [4:0]             idx,
  input  logic [11:0]            csr,
  input  logic                   transfer,
  input  logic                   write,
  input  logic [2:0]             size,
  input  logic                   postexec,
  output logic [DEPTH-1:0][31:0] words,
  output logic [CW-1:0]          len,
  output logic                   bad
);
  logic [CW-1:0] n;

  always_comb begin
    words = '0;
    n     = '0;
    bad   = transfer && ((kind == K_BAD) || (size != SIZE_W32) || ((kind == K_CSR) && !CSR_EN));
    if (transfer) begin
      if (is_fp) begin
        words[n[AW-1:0]] = enc_csr(3'd1, 5'd0, REG_S0, CSR_SCR0);  n = n + CW'(1);
        words[n[AW-1:0]] = enc_csr(3'd2, REG_S0, 5'd0, CSR_MSTAT); n = n + CW'(1);
        words[n[AW-1:0]] = enc_csr(3'd1, 5'd0, REG_S0, CSR_SCR1);  n = n + CW'(1);
        words[n[AW-1:0]] = enc_lui(REG_S0, FS_UPPER);              n = n + CW'(1);
        words[n[AW-1:0]] = enc_csr(3'd2, 5'd0, REG_S0, CSR_MSTAT); n = n + CW'(1);
      end
      case (kind)
        K_CSR: begin
          if (!is_fp) begin
            words[n[AW-1:0]] = enc_csr(3'd1, 5'd0, REG_S0, CSR_SCR0); n = n + CW'(1);
          end
          if (write) begin
            words[n[AW-1:0]] = enc_load(7'h03, REG_S0, DATA_OFF);   n = n + CW'(1);
            words[n[AW-1:0]] = enc_csr(3'd1, 5'd0, REG_S0, csr);    n = n + CW'(1);
          end else begin
            words[n[AW-1:0]] = enc_csr(3'd2, REG_S0, 5'd0, csr);    n = n + CW'(1);
            words[n[AW-1:0]] = enc_store(7'h23, REG_S0, DATA_OFF);  n = n + CW'(1);
          end
          if (!is_fp) begin
            words[n[AW-1:0]] = enc_csr(3'd2, REG_S0, 5'd0, CSR_SCR0); n = n + CW'(1);
          end
        end
        K_GPR: begin
          words[n[AW-1:0]] = write ? enc_load(7'h03, idx, DATA_OFF)
                                   : enc_store(7'h23, idx, DATA_OFF);
          n = n + CW'(1);
        end
        K_FPR: begin
          words[n[AW-1:0]] = write ? enc_load(7'h07, idx, DATA_OFF)
                                   : enc_store(7'h27, idx, DATA_OFF);
          n = n + CW'(1);
        end
        default: ;
      endcase
      if (is_fp) begin
        words[n[AW-1:0]] = enc_csr(3'd2, REG_S0, 5'd0, CSR_SCR1);  n = n + CW'(1);
        words[n[AW-1:0]] = enc_csr(3'd1, 5'd0, REG_S0, CSR_MSTAT); n = n + CW'(1);
        words[n[AW-1:0]] = enc_csr(3'd2, REG_S0, 5'd0, CSR_SCR0);  n = n + CW'(1);
      end
    end
    words[n[AW-1:0]] = postexec ? W_NOP : W_EBREAK;
    len = n + CW'(1);
  end
endmodule

// File: rtl/dbg_regacc_emit.sv
module dbg_regacc_emit
  import dbg_regacc_pkg::*;
#(
  parameter  int DEPTH = 12,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   bad,
  input  logic [DEPTH-1:0][31:0] words,
  input  logic [CW-1:0]          len,
  input  logic                   ready,
  output logic                   valid,
  output logic [AW-1:0]          addr,
  output logic [31:0]            data,
  output logic                   done,
  output logic [CW-1:0]          count,
  output logic                   err
);
  logic          busy;
  logic [AW-1:0] pos;

  assign valid = busy;
  assign addr  = pos;
  assign data  = words[pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pos   <= '0;
      done  <= 1'b0;
      count <= '0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (go) begin
          if (bad) begin
            done  <= 1'b1;
            err   <= 1'b1;
            count <= '0;
          end else begin
            busy <= 1'b1;
            pos  <= '0;
          end
        end
      end else if (ready) begin
        if (CW'(pos) == len - CW'(1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          count <= len;
        end else begin
          pos <= pos + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbg_regacc_seq.sv
module dbg_regacc_seq
  import dbg_regacc_pkg::*;
#(
  parameter  int          DEPTH    = 12,
  parameter  logic [11:0] DATA_OFF = 12'h380,
  parameter  bit          CSR_EN   = 1'b1,
  localparam int          AW       = $clog2(DEPTH),
  localparam int          CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   cmd_regno,
  input  logic          cmd_transfer,
  input  logic          cmd_write,
  input  logic [2:0]    cmd_size,
  input  logic          cmd_postexec,
  input  logic [2:0]    err_in,
  output logic          buf_valid,
  input  logic          buf_ready,
  output logic [AW-1:0] buf_addr,
  output logic [31:0]   buf_data,
  output logic          done,
  output logic [CW-1:0] done_count,
  output logic          err_set,
  output logic [2:0]    err_code
);
  rkind_e                 kind;
  logic                   is_fp;
  logic [4:0]             idx;
  logic [DEPTH-1:0][31:0] words;
  logic [CW-1:0]          len;
  logic                   bad;

  dbg_regacc_classify u_cls (.regno(cmd_regno), .kind(kind), .is_fp(is_fp), .idx(idx));

  dbg_regacc_prog #(.DEPTH(DEPTH), .DATA_OFF(DATA_OFF), .CSR_EN(CSR_EN)) u_prog (
    .kind(kind), .is_fp(is_fp), .idx(idx), .csr(cmd_regno[11:0]),
    .transfer(cmd_transfer), .write(cmd_write), .size(cmd_size),
    .postexec(cmd_postexec), .words(words), .len(len), .bad(bad));

  dbg_regacc_emit #(.DEPTH(DEPTH)) u_emit (
    .clk(clk), .rst_n(rst_n), .go(start && (err_in == 3'd0)), .bad(bad),
    .words(words), .len(len), .ready(buf_ready), .valid(buf_valid),
    .addr(buf_addr), .data(buf_data), .done(done), .count(done_count), .err(err_set));

  assign err_code = err_set ? ERR_NOSUP : 3'd0;
endmodule

// File: rtl/dbg_regacc_seq_chk.sv
module dbg_regacc_seq_chk #(
  parameter  int DEPTH = 12,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    err_in,
  input logic          buf_valid,
  input logic          buf_ready,
  input logic [AW-1:0] buf_addr,
  input logic [31:0]   buf_data,
  input logic          done,
  input logic [CW-1:0] done_count,
  input logic          err_set
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !buf_valid && !done);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_data));

  a_r9_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && buf_ready |=> done || (buf_valid && buf_addr == $past(buf_addr) + AW'(1)));

  a_r9_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> buf_addr == '0);

  a_r9_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> int'(buf_addr) < DEPTH);

  a_r6_final_word: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err_set |-> $past(buf_data) == 32'h0010_0073 || $past(buf_data) == 32'h0000_0013);

  a_r10_count_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err_set |-> done_count == CW'($past(buf_addr)) + CW'(1));

  a_r7_error_shape: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> done && done_count == '0 && !buf_valid);

  a_r8_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_valid && start && err_in != 3'd0 |=> !buf_valid && !done);
endmodule

bind dbg_regacc_seq dbg_regacc_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .err_in(err_in),
  .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
  .buf_data(buf_data), .done(done), .done_count(done_count), .err_set(err_set));

// File: tb/sim_dbg_regacc_seq.sv
module sim_dbg_regacc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cmd_regno = '0;
  logic        cmd_transfer = 1'b0, cmd_write = 1'b0, cmd_postexec = 1'b0;
  logic [2:0]  cmd_size = 3'd2;
  logic [2:0]  err_in = '0;
  logic        buf_valid, buf_ready = 1'b1, done, err_set;
  logic [3:0]  buf_addr, done_count;
  logic [31:0] buf_data;
  logic [2:0]  err_code;

  int checks = 0, failures = 0;
  int cyc = 0, ncap = 0, addr_bad = 0, last_hs = 0, done_cyc = 0;
  bit got_done = 0, got_err = 0, bp_mode = 0;
  int dcnt = 0, ecode = 0;
  logic [31:0] cap [16];
  logic [31:0] exp_w [16];
  int nexp = 0;

  always #5ns clk = ~clk;

  dbg_regacc_seq u0 (.*);

  always @(posedge clk) begin
    if (buf_valid && buf_ready) begin
      if (int'(buf_addr) != ncap) addr_bad++;
      if (ncap < 16) cap[ncap] = buf_data;
      ncap++;
      last_hs = cyc;
    end
    if (done) begin
      got_done = 1; dcnt = int'(done_count); got_err = err_set;
      ecode = int'(err_code); done_cyc = cyc;
    end
    cyc++;
  end

  always @(negedge clk) buf_ready <= bp_mode ? ((cyc % 3) != 1) && ((cyc % 7) != 2) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int ex);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, ex);
    end
  endtask

  function automatic logic [31:0] t_csr(int f3, int rd, int rs1, int csr);
    logic [11:0] c = 12'(csr); logic [4:0] d = 5'(rd); logic [4:0] s = 5'(rs1); logic [2:0] f = 3'(f3);
    return {c, s, f, d, 7'b1110011};
  endfunction
  function automatic logic [31:0] t_ld(int op, int rd);
    logic [11:0] o = 12'h380; logic [4:0] d = 5'(rd); logic [6:0] p = 7'(op);
    return {o, 5'd0, 3'b010, d, p};
  endfunction
  function automatic logic [31:0] t_st(int op, int rs2);
    logic [11:0] o = 12'h380; logic [4:0] s = 5'(rs2); logic [6:0] p = 7'(op);
    return {o[11:5], s, 5'd0, 3'b010, o[4:0], p};
  endfunction

  task automatic push(input logic [31:0] w); exp_w[nexp] = w; nexp++; endtask

  task automatic build(input int r, input bit wr, input bit tr, input bit pe);
    bit fp = (r >= 'h1020 && r <= 'h103F) || (r >= 1 && r <= 3);
    nexp = 0;
    if (tr) begin
      if (fp) begin
        push(t_csr(1, 0, 8, 'h7B2)); push(t_csr(2, 8, 0, 'h300));
        push(t_csr(1, 0, 8, 'h7B3)); push(32'h0000_6437); push(t_csr(2, 0, 8, 'h300));
      end
      if (r < 'h1000) begin
        if (!fp) push(t_csr(1, 0, 8, 'h7B2));
        if (wr) begin push(t_ld('h03, 8)); push(t_csr(1, 0, 8, r)); end
        else    begin push(t_csr(2, 8, 0, r)); push(t_st('h23, 8)); end
        if (!fp) push(t_csr(2, 8, 0, 'h7B2));
      end else if (r < 'h1020) push(wr ? t_ld('h03, r - 'h1000) : t_st('h23, r - 'h1000));
      else push(wr ? t_ld('h07, r - 'h1020) : t_st('h27, r - 'h1020));
      if (fp) begin
        push(t_csr(2, 8, 0, 'h7B3)); push(t_csr(1, 0, 8, 'h300)); push(t_csr(2, 8, 0, 'h7B2));
      end
    end
    push(pe ? 32'h0000_0013 : 32'h0010_0073);
  endtask

  task automatic issue(input int r, input bit wr, input bit tr, input bit pe, input int sz, input int ei);
    @(negedge clk);
    cmd_regno = 16'(r); cmd_write = wr; cmd_transfer = tr; cmd_postexec = pe;
    cmd_size = 3'(sz); err_in = 3'(ei);
    ncap = 0; addr_bad = 0; got_done = 0; got_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 80 && !got_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(input string req, input int r, input bit wr, input bit tr, input bit pe);
    build(r, wr, tr, pe);
    issue(r, wr, tr, pe, 2, 0);
    chk(got_done && !got_err, req, "done without error", got_err, 0);
    chk(ncap == nexp, req, "word count", ncap, nexp);
    chk(dcnt == nexp, "R10", "done_count", dcnt, nexp);
    chk(done_cyc == last_hs + 1, "R10", "done timing", done_cyc, last_hs + 1);
    chk(addr_bad == 0, "R9", "address order", addr_bad, 0);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == exp_w[i], req, $sformatf("word %0d", i), cap[i], exp_w[i]);
  endtask

  task automatic t_reset();
    chk(!buf_valid && !done && !err_set, "R1", "idle after reset", {buf_valid, done, err_set}, 0);
  endtask

  task automatic t_gpr();
    run_seq("R2", 'h1005, 0, 1, 0);
    chk(cap[0] == 32'h3850_2023, "R2", "sw x5 literal", cap[0], 32'h3850_2023);
    run_seq("R2", 'h1005, 1, 1, 0);
    chk(cap[0] == 32'h3800_2283, "R2", "lw x5 literal", cap[0], 32'h3800_2283);
    run_seq("R2", 'h101F, 1, 1, 0);
  endtask

  task automatic t_csr_plain();
    run_seq("R3", 'h300, 0, 1, 0);
    chk(cap[0] == 32'h7B24_1073, "R3", "s0 save literal", cap[0], 32'h7B24_1073);
    run_seq("R3", 'h305, 1, 1, 0);
  endtask

  task automatic t_fpr();
    bp_mode = 1;
    run_seq("R4", 'h1023, 0, 1, 0);
    run_seq("R4", 'h103F, 1, 1, 0);
    bp_mode = 0;
    chk(cap[3] == 32'h0000_6437, "R4", "lui FS literal", cap[3], 32'h0000_6437);
  endtask

  task automatic t_fpcsr();
    run_seq("R5", 'h003, 1, 1, 0);
    chk(ncap == 11, "R5", "eleven words", ncap, 11);
    run_seq("R5", 'h001, 0, 1, 0);
  endtask

  task automatic t_final();
    run_seq("R6", 'h1005, 0, 1, 1);
    run_seq("R6", 'hFFFF, 0, 0, 0);
    chk(ncap == 1, "R6", "no transfer one word", ncap, 1);
  endtask

  task automatic t_bad();
    issue('h1040, 0, 1, 0, 2, 0);
    chk(got_done && got_err && ecode == 2, "R7", "bad regno error", ecode, 2);
    chk(ncap == 0 && dcnt == 0, "R7", "bad regno no writes", ncap, 0);
    issue('h1005, 0, 1, 0, 3, 0);
    chk(got_done && got_err && ncap == 0, "R7", "bad size error", ncap, 0);
  endtask

  task automatic t_errin();
    issue('h1005, 0, 1, 0, 2, 1);
    chk(!got_done && ncap == 0, "R8", "start blocked by error", got_done, 0);
    err_in = '0;
  endtask

  initial begin
    #2ms;
    failures++;
    $display("FAIL R10 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gpr();
    t_csr_plain();
    t_fpr();
    t_fpcsr();
    t_final();
    t_bad();
    t_errin();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule